// File: doc/BRIEF.md
# SYSREF Divider and Burst Pulser

This block turns a fast input clock into a slow alignment strobe for converter links. The clock runs through a chain of three divide stages: a selectable stage that divides by 2, 4 or 8, a programmable stage that divides by 2 plus an 11-bit setting, and a fixed divide-by-4. One strobe period therefore spans 8 × pre × (2 + div) input clocks. The divided waveform passes through a programmable delay of 0 to 63 input clocks. Its rising edge can then be placed precisely against other timing in the system.

After the delay, an output gate decides what reaches the pin. The pin can carry the free-running waveform, stay quiet, or, after a one-cycle request strobe, carry a counted burst of 1 to 16 complete periods. During a burst a busy flag is raised. Requests that arrive while busy are ignored.

Top module: `sysref_gen`

## Requirements
- R1: The pre-select field `cfg_pre` gives a pre-divide of 2, 4 or 8 for the values 1, 2 and 4. Any other value (0, 3, 5, 6, 7) behaves as 1.
- R2: The main divide is 2 + `cfg_div` (0 to 2047), followed by a fixed divide-by-4. The output period is 8 × pre × (2 + `cfg_div`) input clock cycles.
- R3: In continuous mode (`cfg_mode` = 1) the output is high for exactly half of each period and low for the other half.
- R4: In the off modes (`cfg_mode` = 0 or 3) the output stays low.
- R5: In pulsed mode (`cfg_mode` = 2), a request sampled high while idle is accepted, and `busy` is high from the next clock edge.
- R6: An accepted request produces exactly `cfg_count` + 1 pulses. Every pulse, the first included, is high for a full half period, because emission begins on a rising edge of the delayed divider.
- R7: In pulsed mode the output is low whenever no burst is running. `busy` falls at the same edge at which the last pulse ends.
- R8: A request is ignored while `busy` is high. It is also ignored in any mode other than pulsed, where `busy` stays low.
- R9: The delay `cfg_delay` (0 to 63) shifts the output by that many input clocks. After reset is released in continuous mode, the output first goes high at clock edge 1 + `cfg_delay`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pre | input | 3 | Pre-divide select (1, 2, 4 valid) |
| cfg_div | input | 11 | Main divide setting; divide is 2 + value |
| cfg_mode | input | 2 | 0 off, 1 continuous, 2 pulsed, 3 off |
| cfg_count | input | 4 | Burst length minus one |
| cfg_delay | input | 6 | Output delay in input clocks |
| req | input | 1 | One-cycle burst request |
| sysref_out | output | 1 | Divided and gated strobe |
| busy | output | 1 | High while a burst is pending or running |

## Verification
A wrong period counter limit appears as a wrong high or low width on `sysref_out` within one or two periods of the strobe. A bad delay tap moves the first rising edge after reset by a counted number of cycles. A fault in the burst remaining count shows as a pulse total that differs from `cfg_count` + 1 once `busy` falls. A fault in the arming state shows as a truncated first pulse, as output while idle, or as a burst restarted by a request that should have been dropped.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  localparam int PRE_W = 3;
  localparam int DIV_W = 11;
  localparam int PER_W = DIV_W + 6;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_PULSE = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  // illegal selections fall back to the smallest pre-divide
  function automatic logic [3:0] pre_factor(input logic [PRE_W-1:0] sel);
    case (sel)
      3'd2:    return 4'd2;
      3'd4:    return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  // 2*pre from the pre stage, (2+div) from the main stage, 4 from the tail
  function automatic logic [PER_W-1:0] period_cycles(input logic [PRE_W-1:0] sel,
                                                     input logic [DIV_W-1:0] div);
    logic [PER_W-1:0] p;
    p = PER_W'(div) + PER_W'(2);
    p = p * PER_W'(pre_factor(sel));
    return p << 3;
  endfunction
endpackage

// File: rtl/sysref_divchain.sv
module sysref_divchain
  import sysref_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [DIV_W-1:0] div_sel,
  output logic             div_lvl,
  output logic             wrap
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per;

  assign per     = period_cycles(pre_sel, div_sel);
  assign wrap    = (cnt_q >= per - PER_W'(1));
  assign div_lvl = (cnt_q < (per >> 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + PER_W'(1);
  end

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && $stable(per) |-> cnt_q < per);
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0);
endmodule

// File: rtl/sysref_delay.sv
module sysref_delay #(
  parameter int DEPTH = 64,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic             dout
);
  logic [DEPTH-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[DEPTH-3:0], din};
  end

  assign dout = (sel == '0) ? din : sh_q[sel - SEL_W'(1)];

  a_r9_tap_one: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && sel == SEL_W'(1) && $past(sel) == SEL_W'(1) |-> dout == $past(din));
endmodule

// File: rtl/sysref_gate.sv
module sysref_gate
  import sysref_pkg::*;
#(
  parameter int BURST_W = 4,
  localparam int REM_W = BURST_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_e              mode,
  input  logic [BURST_W-1:0] count,
  input  logic               req,
  input  logic               dly,
  output logic               out_q,
  output logic               busy
);
  typedef enum logic [1:0] {G_IDLE, G_ARM, G_EMIT} gst_e;

  gst_e             st_q, st_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic             dly_q;
  logic             rise, fall, pulsed, gate_en;

  assign rise   = dly & ~dly_q;
  assign fall   = ~dly & dly_q;
  assign pulsed = (mode == MODE_PULSE);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (!pulsed) begin
      st_d = G_IDLE;
    end else begin
      case (st_q)
        G_IDLE: if (req) begin
          st_d  = G_ARM;
          rem_d = REM_W'(count) + REM_W'(1);
        end
        G_ARM:  if (rise) st_d = G_EMIT;
        G_EMIT: if (fall) begin
          rem_d = rem_q - REM_W'(1);
          if (rem_q == REM_W'(1)) st_d = G_IDLE;
        end
        default: st_d = G_IDLE;
      endcase
    end
  end

  assign gate_en = (mode == MODE_CONT) ||
                   (pulsed && ((st_q == G_ARM && rise) || st_q == G_EMIT));
  assign busy    = (st_q != G_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= G_IDLE;
      rem_q <= '0;
      dly_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      dly_q <= dly;
      out_q <= gate_en & dly;
    end
  end

  a_r8_busy_req_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && req && !fall |=> $stable(rem_q));
  a_r6_rem_nonzero: assert property (@(posedge clk) disable iff (rst)
    st_q == G_EMIT |-> rem_q != '0);
  a_r7_out_only_in_burst: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && pulsed && $past(pulsed) && out_q |-> $past(st_q != G_IDLE));
  a_r5_busy_after_req: assert property (@(posedge clk) disable iff (rst)
    pulsed && !busy && req |=> busy || !$past(pulsed));
endmodule

// File: rtl/sysref_gen.sv
module sysref_gen
  import sysref_pkg::*;
#(
  parameter int DLY_DEPTH = 64,
  parameter int BURST_W   = 4,
  localparam int DLY_W    = $clog2(DLY_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRE_W-1:0]   cfg_pre,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [1:0]         cfg_mode,
  input  logic [BURST_W-1:0] cfg_count,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic               req,
  output logic               sysref_out,
  output logic               busy
);
  logic  div_lvl, div_wrap, dly_lvl;
  mode_e mode;

  assign mode = mode_e'(cfg_mode);

  sysref_divchain u_div (
    .clk(clk), .rst(rst), .pre_sel(cfg_pre), .div_sel(cfg_div),
    .div_lvl(div_lvl), .wrap(div_wrap)
  );

  sysref_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk(clk), .rst(rst), .sel(cfg_delay), .din(div_lvl), .dout(dly_lvl)
  );

  sysref_gate #(.BURST_W(BURST_W)) u_gate (
    .clk(clk), .rst(rst), .mode(mode), .count(cfg_count), .req(req),
    .dly(dly_lvl), .out_q(sysref_out), .busy(busy)
  );

  a_r9_zero_delay_follow: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && mode == MODE_CONT && $past(mode == MODE_CONT) &&
    cfg_delay == '0 && $past(cfg_delay == '0) |-> sysref_out == $past(div_lvl));
  a_r4_off_is_low: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && (mode == MODE_OFF || mode == MODE_RSVD) &&
    $past(mode == MODE_OFF || mode == MODE_RSVD) |-> !sysref_out);
  a_r2_wrap_ends_low: assert property (@(posedge clk) disable iff (rst)
    div_wrap |-> !div_lvl);
endmodule

// File: tb/sysref_gen_bench.sv
`timescale 1ns/1ps
module sysref_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_pre = 3'd1;
  logic [10:0] cfg_div = '0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [3:0]  cfg_count = '0;
  logic [5:0]  cfg_delay = '0;
  logic        req = 1'b0;
  logic        sysref_out, busy;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sysref_gen u_sysref_gen (
    .clk(clk), .rst(rst), .cfg_pre(cfg_pre), .cfg_div(cfg_div),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_delay(cfg_delay),
    .req(req), .sysref_out(sysref_out), .busy(busy)
  );

  function automatic int exp_period(input int pre, input int dv);
    int f;
    f = (pre == 2) ? 2 : (pre == 4) ? 4 : 1;
    return 2 * f * (dv + 2) * 4;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(input int pre, input int dv, input int md, input int cnt, input int dl);
    @(negedge clk);
    rst = 1'b1; req = 1'b0;
    cfg_pre = 3'(pre); cfg_div = 11'(dv); cfg_mode = 2'(md);
    cfg_count = 4'(cnt); cfg_delay = 6'(dl);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1 R2 R3: period and half-period high time in continuous mode
  task automatic t_continuous(input int pre, input int dv, input int dl);
    int p, hi, lo, guard;
    p = exp_period(pre, dv);
    restart(pre, dv, 1, 0, dl);
    guard = 0;
    while (sysref_out !== 1'b0 && guard < 3 * p) begin @(negedge clk); guard++; end
    while (sysref_out !== 1'b1 && guard < 3 * p) begin @(negedge clk); guard++; end
    hi = 0; lo = 0;
    while (sysref_out === 1'b1 && hi < 2 * p) begin @(negedge clk); hi++; end
    while (sysref_out === 1'b0 && lo < 2 * p) begin @(negedge clk); lo++; end
    check($sformatf("R2 R1 period pre=%0d div=%0d", pre, dv), hi + lo, p);
    check($sformatf("R3 high width pre=%0d div=%0d", pre, dv), hi, p / 2);
  endtask

  // R9: first rising edge after reset release
  task automatic t_delay(input int dl);
    int n;
    restart(1, 0, 1, 0, dl);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sysref_out === 1'b1) break;
    end
    check($sformatf("R9 first edge delay=%0d", dl), n, 1 + dl);
  endtask

  // R4: off modes keep the output low
  task automatic t_off(input int md);
    int highs;
    restart(1, 1, md, 0, 0);
    highs = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (sysref_out === 1'b1) highs++;
    end
    check($sformatf("R4 off mode=%0d high cycles", md), highs, 0);
  endtask

  // R8: request outside pulsed mode never raises busy
  task automatic t_req_cont;
    int bz;
    restart(1, 0, 1, 0, 0);
    repeat (5) @(negedge clk);
    req = 1'b1; @(negedge clk); req = 1'b0;
    bz = 0;
    for (int k = 0; k < 40; k++) begin
      if (busy === 1'b1) bz++;
      @(negedge clk);
    end
    check("R8 busy in continuous mode", bz, 0);
  endtask

  // R5 R6 R7 R8: burst behaviour
  task automatic t_burst(input int pre, input int dv, input int cnt, input int dl, input bit retrig);
    int p, pulses, wrong_w, w, guard, pre_high, post_high;
    bit prev;
    p = exp_period(pre, dv);
    restart(pre, dv, 2, cnt, dl);
    pre_high = 0;
    for (int k = 0; k < 2 * p + 7; k++) begin
      @(negedge clk);
      if (sysref_out === 1'b1) pre_high++;
    end
    check("R7 output low before request", pre_high, 0);
    req = 1'b1; @(negedge clk); req = 1'b0;
    check("R5 busy after request", int'(busy), 1);
    pulses = 0; wrong_w = 0; w = 0; prev = 1'b0; guard = 0;
    while (busy === 1'b1 && guard < (cnt + 4) * p) begin
      if (retrig && guard == p + 3) req = 1'b1;
      else req = 1'b0;
      if (sysref_out === 1'b1) begin
        if (!prev) pulses++;
        w++;
      end else if (prev) begin
        if (w != p / 2) wrong_w++;
        w = 0;
      end
      prev = sysref_out;
      @(negedge clk); guard++;
    end
    req = 1'b0;
    if (prev && w != p / 2) wrong_w++;
    check($sformatf("R6 R8 pulse count cnt=%0d", cnt), pulses, cnt + 1);
    check("R6 pulse widths off", wrong_w, 0);
    check("R7 output low as busy falls", int'(sysref_out), 0);
    post_high = 0;
    for (int k = 0; k < 2 * p; k++) begin
      @(negedge clk);
      if (sysref_out === 1'b1) post_high++;
    end
    check("R7 output low after burst", post_high, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R7 reset output low", int'(sysref_out), 0);
    check("R5 reset busy low", int'(busy), 0);
    t_continuous(1, 0, 0);
    t_continuous(2, 3, 0);
    t_continuous(4, 5, 0);
    t_continuous(3, 0, 0);    // R1 illegal value acts as 1
    t_continuous(0, 2, 0);    // R1 illegal value acts as 1
    t_continuous(1, 2047, 0);
    t_continuous(2, 1, 21);
    t_delay(0);
    t_delay(1);
    t_delay(37);
    t_delay(63);
    t_off(0);
    t_off(3);
    t_req_cont;
    t_burst(1, 0, 0, 0, 1'b0);
    t_burst(2, 1, 3, 5, 1'b1);
    t_burst(1, 2, 15, 0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule